// File: doc/BRIEF.md
# I2C Acknowledge-Polling Sequencer

This block finds out when an I2C target has finished its internal write cycle. The caller closes a write load with STOP, then pulses `go_i`. The sequencer sends START at once, followed by the 7-bit target address and the chosen direction bit. It then samples the acknowledge slot. If the target stays silent, the block sends STOP and tries again. When the target pulls SDA low in the acknowledge slot, the block does not send STOP. It leaves the bus open, with SCL low and SDA released, and pulses `done_o`. The caller's own read or write transfer then carries on from that point.

The block contains its own small bit-level generator, which produces START, a nine-clock byte slot and STOP. A programmable divider times the generator, and every SCL bit has four equal phases. SDA is open-drain: `sda_oe_o` high pulls the line low. There is a cap on the number of attempts. If the target has not acknowledged by the last allowed attempt, the block sends a final STOP and raises `timeout_o`.

Top module: `ackpoll_seq`

## Requirements
- R1: After reset, `scl_o` is 1, `sda_oe_o` is 0, and `busy_o`, `done_o` and `timeout_o` are all 0.
- R2: A `go_i` pulse sampled while the block is idle raises `busy_o` on the next clock edge. The first START follows without any fixed wait. The same edge clears `timeout_o`.
- R3: SDA falls while SCL is high only for START, and rises while SCL is high only for STOP. Apart from these, SDA changes only while SCL is low.
- R4: Every attempt sends the byte {addr_i[6:0], dir} MSB first, where dir is 1 for read (`rd_i`=1) and 0 for write. The address and direction are the values captured at `go_i`. SDA is released during the ninth clock.
- R5: An acknowledge is the bus SDA (`sda_i`) being low when SCL rises for the ninth time in the byte.
- R6: A missing acknowledge is followed by STOP and then a fresh START and address byte.
- R7: On an acknowledge, no STOP is sent. `done_o` pulses high for exactly one cycle on the same edge where `busy_o` falls. The bus is left with `scl_o`=0 and `sda_oe_o`=0.
- R8: If MAX_TRIES attempts in a row are not acknowledged, the block sends exactly MAX_TRIES STARTs and MAX_TRIES STOPs. It then drops `busy_o` and sets `timeout_o`, and `done_o` never pulses. The bus is left idle (`scl_o`=1, `sda_oe_o`=0).
- R9: Within a byte, consecutive SCL rising edges are 4*(div_i+1) clock cycles apart.
- R10: `go_i`, and any change to `addr_i` or `rd_i`, has no effect while `busy_o` is high.
- R11: A `go_i` pulse issued while the bus is held open after a success produces a repeated START and a new round of polling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| go_i | input | 1 | Start polling (one-cycle pulse, honoured when idle) |
| addr_i | input | 7 | Target address |
| rd_i | input | 1 | Direction bit sent with the address (1 = read) |
| div_i | input | DIVW | Divider: each SCL quarter-phase lasts div_i+1 clocks |
| sda_i | input | 1 | Sampled level of the SDA bus line |
| scl_o | output | 1 | SCL level driven to the bus |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| busy_o | output | 1 | Polling in progress |
| done_o | output | 1 | One-cycle pulse: target acknowledged |
| timeout_o | output | 1 | Attempt limit reached without acknowledge |

## Verification
The hardest states to reach are those that depend on how many attempts the target rejects. These are the timeout path, with its last STOP and no done pulse, and the repeated START issued from a bus held open after success. The bench models a target that decodes START, bits and STOP from the bus lines. This model rejects a chosen number of address frames and then acknowledges. Its reject count is swept from zero to beyond the attempt limit, against several divider settings and both directions. Runs follow one another directly, so each run starts from the bus state the previous one left behind, held open or idle.

// File: rtl/ackpoll_pkg.sv
// Shared types for the acknowledge-polling sequencer.
// Assumes: included first in compile order.
package ackpoll_pkg;

    // Bus-level command handed from the sequencer to the bit generator.
    typedef enum logic [1:0] {
        C_IDLE  = 2'd0,
        C_START = 2'd1,
        C_BYTE  = 2'd2,
        C_STOP  = 2'd3
    } bus_cmd_e;

    // Sequencer states.
    typedef enum logic [2:0] {
        S_IDLE      = 3'd0,
        S_START     = 3'd1,
        S_ADDR      = 3'd2,
        S_STOP      = 3'd3,
        S_STOP_LAST = 3'd4
    } seq_state_e;

endpackage

// File: rtl/apoll_tick_gen.sv
// Quarter-phase tick generator.
// Emits one tick every div_i+1 cycles while en_i is high. The count restarts
// whenever en_i is low, so the first tick of a command arrives after a fixed
// number of cycles. Assumes div_i is held stable while en_i is high.
module apoll_tick_gen #(
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_i,
    input  logic [DIVW-1:0] div_i,
    output logic            tick_o
);

    logic [DIVW-1:0] cnt_q;

    // Raise the tick when the count reaches the divider value.
    always_comb tick_o = en_i && (cnt_q == div_i);

    // Count cycles within one quarter phase.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (!en_i)   cnt_q <= '0;
        else if (tick_o)  cnt_q <= '0;
        else              cnt_q <= cnt_q + 1'b1;
    end

    // R9: the count never passes the divider value while enabled.
    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && $past(en_i) && $stable(div_i)) |-> (cnt_q <= div_i));

endmodule

// File: rtl/apoll_bit_engine.sv
// Bit-level I2C generator: START, one 9-clock byte slot, and STOP.
// Each SCL bit takes four ticks. SDA moves in phase 0, while SCL is low.
// SCL rises in phase 1, where the ninth bit samples the acknowledge, and
// falls in phase 3. START and STOP move SDA while SCL is high. START works
// both from an idle bus and from a bus held with SCL low. Assumes the
// sequencer issues a command only while cmd is idle.
module apoll_bit_engine
    import ackpoll_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       cmd_valid_i,
    input  bus_cmd_e   cmd_i,
    input  logic [7:0] byte_i,
    input  logic       sda_i,
    output logic       active_o,
    output logic       done_o,
    output logic       ack_o,
    output logic       scl_o,
    output logic       sda_oe_o
);

    bus_cmd_e   cmd_q;
    logic [1:0] phase_q;
    logic [3:0] bit_q;
    logic [7:0] shift_q;
    logic       scl_q;
    logic       oe_q;
    logic       done_q;
    logic       ack_q;

    // Show that a command is in progress; this enables the divider.
    always_comb active_o = (cmd_q != C_IDLE);

    // Step through the phases of the current command on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q   <= C_IDLE;
            phase_q <= 2'd0;
            bit_q   <= 4'd0;
            shift_q <= 8'd0;
            scl_q   <= 1'b1;
            oe_q    <= 1'b0;
            done_q  <= 1'b0;
            ack_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (cmd_q == C_IDLE) begin
                if (cmd_valid_i) begin
                    cmd_q   <= cmd_i;
                    phase_q <= 2'd0;
                    bit_q   <= 4'd0;
                    shift_q <= byte_i;
                end
            end else if (tick_i) begin
                phase_q <= phase_q + 2'd1;
                unique case (cmd_q)
                    C_START: begin
                        unique case (phase_q)
                            2'd0: oe_q  <= 1'b0;
                            2'd1: scl_q <= 1'b1;
                            2'd2: oe_q  <= 1'b1;
                            default: begin
                                scl_q  <= 1'b0;
                                done_q <= 1'b1;
                                cmd_q  <= C_IDLE;
                            end
                        endcase
                    end
                    C_BYTE: begin
                        unique case (phase_q)
                            2'd0: oe_q <= (bit_q == 4'd8) ? 1'b0 : ~shift_q[7];
                            2'd1: begin
                                scl_q <= 1'b1;
                                if (bit_q == 4'd8) ack_q <= ~sda_i;
                            end
                            2'd2: ;
                            default: begin
                                scl_q <= 1'b0;
                                if (bit_q == 4'd8) begin
                                    done_q <= 1'b1;
                                    cmd_q  <= C_IDLE;
                                end else begin
                                    bit_q   <= bit_q + 4'd1;
                                    shift_q <= {shift_q[6:0], 1'b0};
                                end
                            end
                        endcase
                    end
                    default: begin
                        unique case (phase_q)
                            2'd0: oe_q  <= 1'b1;
                            2'd1: scl_q <= 1'b1;
                            2'd2: oe_q  <= 1'b0;
                            default: begin
                                done_q <= 1'b1;
                                cmd_q  <= C_IDLE;
                            end
                        endcase
                    end
                endcase
            end
        end
    end

    assign done_o   = done_q;
    assign ack_o    = ack_q;
    assign scl_o    = scl_q;
    assign sda_oe_o = oe_q;

    // R3: SDA may change under a high SCL only during START or STOP.
    p_sda_edge_in_ctrl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_q && $past(scl_q) && (oe_q != $past(oe_q)))
        |-> ($past(cmd_q) == C_START || $past(cmd_q) == C_STOP));

    // R4: SDA is released in the ninth clock of a byte.
    p_ninth_released_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == C_BYTE && bit_q == 4'd8 && phase_q != 2'd0) |-> !oe_q);

    // R3: a finished START leaves SCL low with SDA pulled low.
    p_start_ends_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cmd_q) == C_START && done_q) |-> (!scl_q && oe_q));

endmodule

// File: rtl/apoll_seq_fsm.sv
// Attempt sequencer. On go it captures the address and direction, then loops
// START -> address byte -> (no ACK) STOP until an ACK arrives or MAX_TRIES
// attempts have failed. On ACK it stops without sending STOP and pulses done.
// Assumes the bit engine answers every command with exactly one done pulse.
module apoll_seq_fsm
    import ackpoll_pkg::*;
#(
    parameter int MAX_TRIES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go_i,
    input  logic [6:0] addr_i,
    input  logic       rd_i,
    input  logic       eng_done_i,
    input  logic       eng_ack_i,
    output logic       cmd_valid_o,
    output bus_cmd_e   cmd_o,
    output logic [7:0] byte_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       timeout_o
);

    localparam int TRW = $clog2(MAX_TRIES + 1);
    localparam logic [TRW-1:0] LAST_TRY = TRW'(MAX_TRIES - 1);

    seq_state_e     state_q;
    logic [TRW-1:0] tries_q;
    logic [7:0]     byte_q;
    logic           cmd_valid_q;
    bus_cmd_e       cmd_q;
    logic           done_q;
    logic           timeout_q;

    // Busy covers every state except idle.
    always_comb busy_o = (state_q != S_IDLE);

    // Advance through the attempt loop and issue bus commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= S_IDLE;
            tries_q     <= '0;
            byte_q      <= 8'd0;
            cmd_valid_q <= 1'b0;
            cmd_q       <= C_IDLE;
            done_q      <= 1'b0;
            timeout_q   <= 1'b0;
        end else begin
            cmd_valid_q <= 1'b0;
            done_q      <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (go_i) begin
                        byte_q      <= {addr_i, rd_i};
                        tries_q     <= '0;
                        timeout_q   <= 1'b0;
                        cmd_q       <= C_START;
                        cmd_valid_q <= 1'b1;
                        state_q     <= S_START;
                    end
                end
                S_START: begin
                    if (eng_done_i) begin
                        cmd_q       <= C_BYTE;
                        cmd_valid_q <= 1'b1;
                        state_q     <= S_ADDR;
                    end
                end
                S_ADDR: begin
                    if (eng_done_i) begin
                        if (eng_ack_i) begin
                            done_q  <= 1'b1;
                            state_q <= S_IDLE;
                        end else begin
                            cmd_q       <= C_STOP;
                            cmd_valid_q <= 1'b1;
                            if (tries_q == LAST_TRY) begin
                                state_q <= S_STOP_LAST;
                            end else begin
                                tries_q <= tries_q + 1'b1;
                                state_q <= S_STOP;
                            end
                        end
                    end
                end
                S_STOP: begin
                    if (eng_done_i) begin
                        cmd_q       <= C_START;
                        cmd_valid_q <= 1'b1;
                        state_q     <= S_START;
                    end
                end
                default: begin
                    if (eng_done_i) begin
                        timeout_q <= 1'b1;
                        state_q   <= S_IDLE;
                    end
                end
            endcase
        end
    end

    assign cmd_valid_o = cmd_valid_q;
    assign cmd_o       = cmd_q;
    assign byte_o      = byte_q;
    assign done_o      = done_q;
    assign timeout_o   = timeout_q;

    // R2: go while idle makes the block busy on the next edge.
    p_go_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && go_i) |=> busy_o);

    // R7: done is a single-cycle pulse and never coincides with busy.
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R8: the attempt counter stays below the limit; timeout excludes done.
    p_tries_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tries_q < TRW'(MAX_TRIES));
    p_timeout_no_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> !done_o);

    // R10: the captured byte holds while busy.
    p_byte_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(byte_q));

endmodule

// File: rtl/ackpoll_seq.sv
// Top level of the acknowledge-polling sequencer. Ties the divider, the
// bit-level bus generator and the attempt sequencer together. Assumes a
// single master, a target that does not stretch SCL, and div_i held stable
// while busy.
module ackpoll_seq
    import ackpoll_pkg::*;
#(
    parameter int DIVW      = 8,
    parameter int MAX_TRIES = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go_i,
    input  logic [6:0]      addr_i,
    input  logic            rd_i,
    input  logic [DIVW-1:0] div_i,
    input  logic            sda_i,
    output logic            scl_o,
    output logic            sda_oe_o,
    output logic            busy_o,
    output logic            done_o,
    output logic            timeout_o
);

    logic       tick;
    logic       eng_active;
    logic       eng_done;
    logic       eng_ack;
    logic       cmd_valid;
    bus_cmd_e   cmd;
    logic [7:0] cmd_byte;

    apoll_tick_gen #(.DIVW(DIVW)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (eng_active),
        .div_i  (div_i),
        .tick_o (tick)
    );

    apoll_bit_engine u_eng (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .cmd_valid_i (cmd_valid),
        .cmd_i       (cmd),
        .byte_i      (cmd_byte),
        .sda_i       (sda_i),
        .active_o    (eng_active),
        .done_o      (eng_done),
        .ack_o       (eng_ack),
        .scl_o       (scl_o),
        .sda_oe_o    (sda_oe_o)
    );

    apoll_seq_fsm #(.MAX_TRIES(MAX_TRIES)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .go_i        (go_i),
        .addr_i      (addr_i),
        .rd_i        (rd_i),
        .eng_done_i  (eng_done),
        .eng_ack_i   (eng_ack),
        .cmd_valid_o (cmd_valid),
        .cmd_o       (cmd),
        .byte_o      (cmd_byte),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .timeout_o   (timeout_o)
    );

    // R7: after done, SCL stays low; no STOP follows a success.
    p_held_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!scl_o && !sda_oe_o));

    // R8: a timeout leaves the bus idle.
    p_idle_after_timeout_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_o && !busy_o) |-> (scl_o && !sda_oe_o));

endmodule

// File: tb/test_ackpoll_seq.sv
// Bench: a modelled target decodes the bus, rejects K frames then ACKs.
// Sweeps K, divider and direction; checks bus counts, bytes and timing.
module test_ackpoll_seq;

    localparam int CLK_PERIOD = 10;
    localparam int DIVW       = 4;
    localparam int MAXT       = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            go = 1'b0;
    logic [6:0]      addr = 7'd0;
    logic            rd = 1'b0;
    logic [DIVW-1:0] div = '0;
    logic            scl, sda_oe, busy, done, timeout;
    logic            ack_drv = 1'b0;
    logic            sda_bus;

    int n_chk = 0;
    int n_bad = 0;

    // Monitor state (per run).
    int       cyc = 0;
    int       starts, stops, dones, byte_bad, per_bad, bitcnt, last_rise;
    int       k_rej;
    logic [7:0] exp_byte;
    logic [7:0] shreg;
    logic       ack_this;
    logic       m_scl = 1'b1, m_sda = 1'b1;

    assign sda_bus = ~sda_oe & ~ack_drv;

    always #(CLK_PERIOD/2) clk = ~clk;

    ackpoll_seq #(.DIVW(DIVW), .MAX_TRIES(MAXT)) i_ackpoll_seq (
        .clk(clk), .rst_n(rst_n), .go_i(go), .addr_i(addr), .rd_i(rd),
        .div_i(div), .sda_i(sda_bus), .scl_o(scl), .sda_oe_o(sda_oe),
        .busy_o(busy), .done_o(done), .timeout_o(timeout)
    );

    task automatic check(input string req, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // Bus decoder and target model.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (done) dones <= dones + 1;
        if (scl && m_scl && (sda_bus != m_sda)) begin
            if (!sda_bus) begin
                ack_this = (starts >= k_rej);
                starts <= starts + 1;
                bitcnt  = 0;
            end else begin
                stops <= stops + 1;
            end
        end else if (scl && !m_scl) begin
            if (bitcnt >= 1 && bitcnt <= 8 && (cyc - last_rise) != 4*(int'(div)+1))
                per_bad <= per_bad + 1;
            last_rise = cyc;
            if (bitcnt < 8) shreg = {shreg[6:0], sda_bus};
            if (bitcnt < 15) bitcnt = bitcnt + 1;
            if (bitcnt == 8 && shreg != exp_byte) byte_bad <= byte_bad + 1;
        end
        if (!scl && bitcnt == 8 && ack_this) ack_drv <= 1'b1;
        if (!scl && bitcnt == 9) ack_drv <= 1'b0;
        m_scl <= scl;
        m_sda <= sda_bus;
    end

    // Global watchdog.
    always @(posedge clk) begin
        if (cyc > 190000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic run(input logic [6:0] a, input logic r, input int k,
                       input int d, input bit poke);
        int  exp_st;
        bit  ok;
        bit  was_held;
        was_held = !scl;
        @(negedge clk);
        div = DIVW'(d); addr = a; rd = r;
        exp_byte = {a, r};
        k_rej = k; starts = 0; stops = 0; dones = 0; byte_bad = 0; per_bad = 0;
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        check("R2 busy after go", int'(busy), 1);
        check("R2 timeout cleared by go", int'(timeout), 0);
        for (int i = 0; i < 20000 && busy; i++) begin
            @(negedge clk);
            if (poke && i == 37) begin
                addr = ~a; rd = ~r; go = 1'b1;
            end else if (poke && i == 38) begin
                go = 1'b0;
            end
        end
        check("watchdog run ended", int'(busy), 0);
        @(negedge clk);
        ok = (k < MAXT);
        exp_st = ok ? k + 1 : MAXT;
        check(was_held ? "R11 repeated start count" : "R6 start count", starts, exp_st);
        check(ok ? "R6 stop count" : "R8 stop count", stops, ok ? k : MAXT);
        check(ok ? "R7 done pulses" : "R8 no done", dones, ok ? 1 : 0);
        check("R8 timeout flag", int'(timeout), ok ? 0 : 1);
        check(poke ? "R10 byte unchanged by busy go" : "R4 address byte", byte_bad, 0);
        check("R9 SCL bit period", per_bad, 0);
        check(ok ? "R7 scl held low" : "R8 scl idle", int'(scl), ok ? 0 : 1);
        check("R7 sda released", int'(sda_oe), 0);
        check("R5 ack only in ninth slot", int'(ack_drv), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 scl", int'(scl), 1);
        check("R1 sda_oe", int'(sda_oe), 0);
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check("R1 timeout", int'(timeout), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", int'(busy), 0);
        for (int d = 0; d < 4; d++)
            for (int k = 0; k <= MAXT + 1; k++)
                for (int r = 0; r < 2; r++)
                    run(7'((d * 37 + k * 11 + r * 5 + 18) % 128), r[0], k, d, 1'b0);
        run(7'h5A, 1'b1, 2, 1, 1'b1);
        run(7'h2B, 1'b0, 0, 0, 1'b0);
        run(7'h7F, 1'b1, 0, 2, 1'b0);
        run(7'h00, 1'b0, MAXT, 0, 1'b0);
        run(7'h41, 1'b0, 1, 0, 1'b0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule